// File: doc/BRIEF.md
# Shared Engine Enable Gate with Drain Wait

This block switches a shared FIFO engine on and off for several client channels. Each client sends a one-cycle enable request when it starts to use the engine and a one-cycle disable request when it is done. A saturating use counter records how many clients are active. The engine-enable output goes high when the first client arrives.

When the last client leaves, the engine is not switched off at once. The block enters a drain wait and watches a 32-bit FIFO status word. It releases the engine when every bit selected by a fixed mask reads one. If that does not happen within a parameterised number of cycles, the block switches the engine off anyway and raises a sticky warning flag. While the drain wait runs, a busy output is high and any new request is dropped, so callers must retry once busy is low.

Top module: `eng_use_gate`

## Requirements
- R1: After synchronous reset, `eng_en`, `busy` and `drain_warn` are low and the use count is zero.
- R2: An accepted enable request taken while the count is zero raises `eng_en` on the same clock edge. Every accepted enable request adds one to the count.
- R3: The use count is 4 bits wide. An enable request at 15 leaves it at 15, so from any higher number of enables exactly 15 disables are needed to start a drain.
- R4: An accepted disable request lowers the count by one. When the count goes from one to zero, `busy` rises on that edge and `eng_en` stays high.
- R5: The FIFOs are empty when (`fifo_stat` AND 32'h02FFF000) equals 32'h02FFF000. If this holds at a clock edge during the drain wait, `eng_en` and `busy` both fall on that edge, so the wait lasts one cycle when the status is already empty.
- R6: If the FIFOs have not reported empty after TIMEOUT_CYC drain cycles, `eng_en` and `busy` fall on the edge that ends the last of those cycles, and `drain_warn` is set on that same edge.
- R7: A disable request while the count is zero has no effect. The count stays at zero and does not wrap.
- R8: Enable and disable requests that arrive while `busy` is high are ignored.
- R9: `drain_warn` stays set until a `warn_clr` pulse. A timeout and a clear on the same edge leave the flag set.
- R10: An enable and a disable request on the same edge cancel each other, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | One-cycle pulse: a client starts using the engine |
| dis_req | input | 1 | One-cycle pulse: a client stops using the engine |
| warn_clr | input | 1 | Clears the sticky timeout warning |
| fifo_stat | input | 32 | FIFO status word; the masked bits read one when the FIFOs are empty |
| eng_en | output | 1 | Enable for the shared engine |
| busy | output | 1 | High while a drain wait is in progress; requests are dropped |
| drain_warn | output | 1 | Sticky flag: a drain wait ended by timeout |

## Verification
Two pairs of functions can act on the same edge. The first pair is a timeout and a warning clear. The bench holds `warn_clr` high for the whole of a drain that times out and expects the flag to be set when the wait ends. A later clear on its own must then lower it. The second pair is enable and disable arriving together: both are pulsed in one cycle at count one, and a single disable afterwards must still start a drain.

// File: rtl/eng_gate_pkg.sv
package eng_gate_pkg;

    // Status bits that must all read one before the engine may be released
    localparam logic [31:0] DRAIN_MASK = 32'h02FF_F000;

    typedef enum logic {
        GATE_RUN   = 1'b0,
        GATE_DRAIN = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic inc;
        logic dec;
    } cnt_cmd_t;

    function automatic logic fifos_empty(input logic [31:0] stat);
        return (stat & DRAIN_MASK) == DRAIN_MASK;
    endfunction

endpackage

// File: rtl/use_counter.sv
module use_counter
    import eng_gate_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_t         cmd,
    output logic [CNT_W-1:0] cnt,
    output logic             is_zero,
    output logic             is_one
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == CNT_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.inc && !cmd.dec) begin
            if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
        end else if (cmd.dec && !cmd.inc) begin
            if (cnt != '0) cnt <= cnt - CNT_ONE;
        end
    end

    // R3: saturation at the top
    assert_sat_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.inc && !cmd.dec && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R7: clamp at zero
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd.dec && !cmd.inc && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/drain_timer.sv
module drain_timer #(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(TIMEOUT_CYC) + 1;
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

    logic [TW-1:0] tmr;

    assign expire = run && (tmr == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) tmr <= '0;
        else if (tmr != LAST) tmr <= tmr + TW'(1);
    end

    // R6: the timer never passes the last cycle of the window
    assert_tmr_bound_R6: assert property (@(posedge clk) disable iff (rst)
        tmr <= LAST);

endmodule

// File: rtl/eng_use_gate.sv
module eng_use_gate
    import eng_gate_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_req,
    input  logic        dis_req,
    input  logic        warn_clr,
    input  logic [31:0] fifo_stat,
    output logic        eng_en,
    output logic        busy,
    output logic        drain_warn
);
    gate_state_e      state;
    cnt_cmd_t         cmd;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero, cnt_one;
    logic             expire;
    logic             accept, do_en, do_dis;
    logic             empty, start_drain, drain_done, timeout_hit;

    assign busy        = (state == GATE_DRAIN);
    assign accept      = !busy;
    assign do_en       = accept && en_req && !dis_req;
    assign do_dis      = accept && dis_req && !en_req;
    assign cmd.inc     = do_en;
    assign cmd.dec     = do_dis;
    assign empty       = fifos_empty(fifo_stat);
    assign start_drain = do_dis && cnt_one;
    assign drain_done  = busy && (empty || expire);
    assign timeout_hit = busy && !empty && expire;

    use_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .cnt     (cnt),
        .is_zero (cnt_zero),
        .is_one  (cnt_one)
    );

    drain_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) tmr_i (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GATE_RUN;
        end else begin
            unique case (state)
                GATE_RUN:   if (start_drain) state <= GATE_DRAIN;
                GATE_DRAIN: if (drain_done)  state <= GATE_RUN;
                default:    state <= GATE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    eng_en <= 1'b0;
        else if (do_en && cnt_zero) eng_en <= 1'b1;
        else if (drain_done)        eng_en <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)              drain_warn <= 1'b0;
        else if (timeout_hit) drain_warn <= 1'b1;
        else if (warn_clr)    drain_warn <= 1'b0;
    end

    // R2: the engine only switches on when the count was zero
    assert_on_from_zero_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_en) |-> ($past(cnt) == '0));

    // R4: a drain wait always has the engine still enabled
    assert_busy_keeps_en_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> eng_en);

    // R5: engine off means no users and no drain
    assert_off_means_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !eng_en |-> (cnt == '0 && !busy));

    // R6: a fresh warning coincides with the forced switch-off
    assert_warn_with_off_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(drain_warn) |-> $fell(eng_en));

    // R8: requests during a drain leave the count alone
    assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (cnt == '0));

    // R9: a clear alone lowers the flag only without a timeout
    assert_warn_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (drain_warn && !warn_clr) |=> drain_warn);

endmodule

// File: tb/eng_use_gate_tb_top.sv
module eng_use_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TOUT       = 16;
    localparam logic [31:0] MASK = 32'h02FF_F000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_req = 1'b0, dis_req = 1'b0, warn_clr = 1'b0;
    logic [31:0] fifo_stat = MASK;
    logic        eng_en, busy, drain_warn;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eng_use_gate #(.CNT_W(4), .TIMEOUT_CYC(TOUT)) dut_i (
        .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
        .warn_clr(warn_clr), .fifo_stat(fifo_stat),
        .eng_en(eng_en), .busy(busy), .drain_warn(drain_warn)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic e, input logic d);
        en_req = e; dis_req = d;
        @(negedge clk);
        en_req = 0; dis_req = 0;
    endtask

    // counts cycles while busy is high, bounded
    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 4*TOUT) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk("R1 eng_en", eng_en, 0);
        chk("R1 busy", busy, 0);
        chk("R1 warn", drain_warn, 0);

        // R2 R3 R4 R5: sweep of user counts, empty FIFOs
        for (int k = 1; k <= 17; k++) begin
            int e;
            e = (k > 15) ? 15 : k;
            for (int i = 0; i < k; i++) begin
                cyc(1, 0);
                if (i == 0) chk("R2 on after first enable", eng_en, 1);
            end
            for (int i = 0; i < e - 1; i++) cyc(0, 1);
            chk("R3 still on before last disable", eng_en, 1);
            chk("R4 no drain before last disable", busy, 0);
            cyc(0, 1);
            chk("R4 drain starts", busy, 1);
            chk("R4 en held", eng_en, 1);
            busy_len(n);
            chk("R5 one-cycle drain", n, 1);
            chk("R5 off after drain", eng_en, 0);
        end

        // R7: disables at zero do not wrap
        cyc(0, 1); cyc(0, 1); cyc(0, 1);
        chk("R7 off at zero", eng_en, 0);
        chk("R7 no drain at zero", busy, 0);
        cyc(1, 0);
        cyc(0, 1);
        chk("R7 one disable after one enable drains", busy, 1);
        busy_len(n);

        // R5 R6: mask sweep over every status bit
        for (int b = 0; b < 32; b++) begin
            logic [31:0] s;
            int expn;
            s = MASK & ~(32'h1 << b);
            s = s | (~MASK & (32'h1 << b));
            fifo_stat = s;
            expn = ((MASK >> b) & 1) ? TOUT : 1;
            cyc(1, 0);
            cyc(0, 1);
            busy_len(n);
            chk($sformatf("R5/R6 bit %0d drain length", b), n, expn);
            chk("R6 off after wait", eng_en, 0);
            chk("R6 warn", drain_warn, (expn == TOUT) ? 1 : 0);
            warn_clr = 1; @(negedge clk); warn_clr = 0;
            chk("R9 clear alone lowers warn", drain_warn, 0);
        end

        // R8: requests during drain ignored
        fifo_stat = 32'h0;
        cyc(1, 0);
        cyc(0, 1);
        cyc(1, 0); cyc(0, 1); cyc(1, 0);
        busy_len(n);
        chk("R8 drain length unchanged", n + 3, TOUT);
        chk("R8 off after drain", eng_en, 0);
        cyc(0, 1);
        chk("R8 no user left over", busy, 0);
        warn_clr = 1; @(negedge clk); warn_clr = 0;

        // R9: timeout with clear held the whole time
        cyc(1, 0);
        warn_clr = 1;
        cyc(0, 1);
        busy_len(n);
        warn_clr = 0;
        chk("R9 set beats clear", drain_warn, 1);
        @(negedge clk);
        chk("R9 sticky", drain_warn, 1);
        warn_clr = 1; @(negedge clk); warn_clr = 0;
        chk("R9 cleared", drain_warn, 0);

        // R10: simultaneous enable and disable cancel
        fifo_stat = MASK;
        cyc(1, 0);
        cyc(1, 1);
        chk("R10 no drain on both", busy, 0);
        chk("R10 still on", eng_en, 1);
        cyc(0, 1);
        chk("R10 count was one", busy, 1);
        busy_len(n);
        chk("R10 off", eng_en, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule